// File: doc/BRIEF.md
# Debounced Four-Limit Threshold Monitor

This block watches a stream of conversion results from a round-robin sampler. Each result carries a channel index. For each channel, the block holds four programmable limits: two lower bounds and two upper bounds. It tests every arriving result against the four limits of its own channel. A limit is only declared in fault after a run of violating results for that channel. The length of the run can be set for each limit.

A single result that is inside the limit ends the run at once and clears the fault. Each channel reports the OR of its four limit faults. A live status vector shows the raw, unfiltered outcome of the most recent test of every limit. Each channel can be set to treat its results as unsigned voltage codes or as signed temperature codes.

Top module: `thresh_watch`

## Requirements
- R1: While reset is asserted and after its release, `lim_fault`, `ch_fault` and `live_stat` are all zero until a sample arrives.
- R2: The 2-bit run setting of a limit selects 1, 2, 4 or 6 consecutive violating samples for codes 00, 01, 10 and 11. The fault bit rises on the clock edge that takes in the last sample of the run.
- R3: One non-violating sample for a channel clears that limit's fault and its run count on that same edge.
- R4: Bit `c` of `ch_fault` is the OR of `lim_fault[4c+3:4c]`. Within a channel, the limit index k is 0 for lower bound A, 1 for lower bound B, 2 for upper bound A and 3 for upper bound B.
- R5: An upper limit is violated only when the result is strictly greater than the limit. A lower limit is violated only when the result is strictly less than the limit. A result equal to the limit does not violate it.
- R6: An upper limit set to all ones, or a lower limit set to zero, never violates and never faults, whatever the channel type.
- R7: Status bit `4c+k` of `live_stat` holds the violation outcome of limit k for the most recent sample of channel c.
- R8: When bit c of `cfg_signed` is 1, the results and limits of channel c are compared as two's complement numbers. When the bit is 0, they are compared as unsigned numbers.
- R9: A cycle without `smp_vld`, or a sample for another channel, leaves a limit's run count and fault unchanged. Runs that are interleaved with other channels still complete.
- R10: Changing a limit's run setting clears that limit's run count and fault on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | A conversion result is present this cycle |
| smp_ch | input | CHW | Channel index of the result |
| smp_val | input | DW | Conversion result |
| cfg_lim | input | NCH*4*DW | Limit values. Limit (c,k) is in bits [(4c+k)*DW +: DW] |
| cfg_run | input | NCH*4*2 | Run settings. Limit (c,k) is in bits [(4c+k)*2 +: 2] |
| cfg_signed | input | NCH | Per-channel signed comparison select |
| lim_fault | output | NCH*4 | Filtered fault for each limit, bit 4c+k |
| ch_fault | output | NCH | Per-channel fault |
| live_stat | output | NCH*4 | Raw violation outcome of the latest sample, bit 4c+k |

## Verification
The hardest case to reach is a six-sample run that is interleaved with samples for other channels and with idle cycles. In the middle of such a run, the run setting changes or an equal-to-limit sample arrives.

Directed sequences build runs of exactly one short of the threshold, then end them with an in-limit sample or a setting change. A long random phase follows. It draws sample values close to randomly chosen limits, so that runs frequently reach every count setting. A behavioural model is compared against all outputs on every clock.

// File: rtl/tw_pkg.sv
package tw_pkg;
   localparam int LIMS = 4;
   localparam int RUNW = 3;

   typedef enum logic [1:0] {
      LIM_LO_A = 2'd0,
      LIM_LO_B = 2'd1,
      LIM_HI_A = 2'd2,
      LIM_HI_B = 2'd3
   } lim_kind_e;

   function automatic logic [RUNW-1:0] run_need(input logic [1:0] code);
      case (code)
         2'b00:   run_need = RUNW'(1);
         2'b01:   run_need = RUNW'(2);
         2'b10:   run_need = RUNW'(4);
         default: run_need = RUNW'(6);
      endcase
   endfunction
endpackage

// File: rtl/tw_cmp.sv
module tw_cmp #(
   parameter int DW    = 10,
   parameter bit UPPER = 1'b1
) (
   input  logic [DW-1:0] val,
   input  logic [DW-1:0] lim,
   input  logic          sgn,
   output logic          viol
);
   logic off;
   logic beyond;

   generate
      if (UPPER) begin : g_upper
         assign off    = (lim == {DW{1'b1}});
         assign beyond = sgn ? ($signed(val) > $signed(lim)) : (val > lim);
      end else begin : g_lower
         assign off    = (lim == {DW{1'b0}});
         assign beyond = sgn ? ($signed(val) < $signed(lim)) : (val < lim);
      end
   endgenerate

   assign viol = beyond & ~off;
endmodule

// File: rtl/tw_filter.sv
module tw_filter
   import tw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  logic       viol,
   input  logic [1:0] run_set,
   output logic       flt,
   output logic       stat
);
   logic [RUNW-1:0] cnt;
   logic [1:0]      prev_set;
   logic [RUNW-1:0] need;
   logic [RUNW:0]   cnt_inc;

   assign need    = run_need(run_set);
   assign cnt_inc = {1'b0, cnt} + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         flt      <= 1'b0;
         stat     <= 1'b0;
         prev_set <= '0;
      end else begin
         prev_set <= run_set;
         if (hit) stat <= viol;
         if (run_set != prev_set) begin
            cnt <= '0;
            flt <= 1'b0;
         end else if (hit) begin
            if (viol) begin
               if (cnt < need) cnt <= cnt_inc[RUNW-1:0];
               flt <= (cnt_inc >= {1'b0, need});
            end else begin
               cnt <= '0;
               flt <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/thresh_watch.sv
module thresh_watch #(
   parameter int NCH = 4,
   parameter int DW  = 10,
   localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int NLIM = NCH * tw_pkg::LIMS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [CHW-1:0]    smp_ch,
   input  logic [DW-1:0]     smp_val,
   input  logic [NLIM*DW-1:0] cfg_lim,
   input  logic [NLIM*2-1:0] cfg_run,
   input  logic [NCH-1:0]    cfg_signed,
   output logic [NLIM-1:0]   lim_fault,
   output logic [NCH-1:0]    ch_fault,
   output logic [NLIM-1:0]   live_stat
);
   generate
      if (DW < 2) begin : g_bad_dw
         $error("thresh_watch: DW must be at least 2");
      end
      if (NCH < 1) begin : g_bad_nch
         $error("thresh_watch: NCH must be at least 1");
      end
   endgenerate

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic hit;
         assign hit = smp_vld && (smp_ch == CHW'(c));

         for (genvar k = 0; k < tw_pkg::LIMS; k++) begin : g_lim
            localparam int IDX = c * tw_pkg::LIMS + k;
            logic viol;

            tw_cmp #(.DW(DW), .UPPER(k >= 2)) u_cmp (
               .val  (smp_val),
               .lim  (cfg_lim[IDX*DW +: DW]),
               .sgn  (cfg_signed[c]),
               .viol (viol)
            );

            tw_filter u_flt (
               .clk     (clk),
               .rst_n   (rst_n),
               .hit     (hit),
               .viol    (viol),
               .run_set (cfg_run[IDX*2 +: 2]),
               .flt     (lim_fault[IDX]),
               .stat    (live_stat[IDX])
            );
         end

         assign ch_fault[c] = |lim_fault[c*tw_pkg::LIMS +: tw_pkg::LIMS];
      end
   endgenerate
endmodule

// File: rtl/thresh_watch_chk.sv
module thresh_watch_chk #(
   parameter int NCH = 4,
   parameter int DW  = 10,
   localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int NLIM = NCH * 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               smp_vld,
   input logic [CHW-1:0]     smp_ch,
   input logic [DW-1:0]      smp_val,
   input logic [NLIM*DW-1:0] cfg_lim,
   input logic [NLIM*2-1:0]  cfg_run,
   input logic [NCH-1:0]     cfg_signed,
   input logic [NLIM-1:0]    lim_fault,
   input logic [NCH-1:0]     ch_fault,
   input logic [NLIM-1:0]    live_stat
);
   generate
      for (genvar c = 0; c < NCH; c++) begin : g_c
         logic hit_c;
         assign hit_c = smp_vld && (smp_ch == CHW'(c));

         p_chan_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ch_fault[c] |-> (lim_fault[c*4 +: 4] != 4'b0));

         for (genvar k = 0; k < 4; k++) begin : g_k
            localparam int I = c * 4 + k;

            p_fault_needs_stat_r3: assert property (@(posedge clk) disable iff (!rst_n)
               lim_fault[I] |-> live_stat[I]);

            p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
               (!hit_c && $stable(cfg_run[I*2 +: 2])) |=> $stable(lim_fault[I]));

            p_setchg_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
               !$stable(cfg_run[I*2 +: 2]) |=> !lim_fault[I]);

            if (k >= 2) begin : g_up
               p_upper_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
                  (hit_c && cfg_lim[I*DW +: DW] == {DW{1'b1}}) |=> !live_stat[I]);
            end else begin : g_lo
               p_lower_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
                  (hit_c && cfg_lim[I*DW +: DW] == {DW{1'b0}}) |=> !live_stat[I]);
            end
         end
      end
   endgenerate
endmodule

bind thresh_watch thresh_watch_chk #(.NCH(NCH), .DW(DW)) u_chk (.*);

// File: tb/thresh_watch_bench.sv
module thresh_watch_bench;
   localparam int NCH  = 4;
   localparam int DW   = 10;
   localparam int CHW  = 2;
   localparam int NLIM = NCH * 4;
   localparam int FULL = 1 << DW;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               smp_vld = 1'b0;
   logic [CHW-1:0]     smp_ch = '0;
   logic [DW-1:0]      smp_val = '0;
   logic [NLIM*DW-1:0] cfg_lim;
   logic [NLIM*2-1:0]  cfg_run;
   logic [NCH-1:0]     cfg_signed;
   logic [NLIM-1:0]    lim_fault;
   logic [NCH-1:0]     ch_fault;
   logic [NLIM-1:0]    live_stat;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   int m_cnt [NLIM];
   int m_flt [NLIM];
   int m_stat[NLIM];
   int m_prev[NLIM];

   always #5 clk = ~clk;

   thresh_watch #(.NCH(NCH), .DW(DW)) u_thresh_watch (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_ch(smp_ch),
      .smp_val(smp_val), .cfg_lim(cfg_lim), .cfg_run(cfg_run),
      .cfg_signed(cfg_signed), .lim_fault(lim_fault), .ch_fault(ch_fault),
      .live_stat(live_stat)
   );

   function automatic int sx(input int v, input bit s);
      return (s && v >= FULL / 2) ? v - FULL : v;
   endfunction

   function automatic int need_of(input int code);
      case (code)
         0: return 1;
         1: return 2;
         2: return 4;
         default: return 6;
      endcase
   endfunction

   // behavioural reference model, updated on each rising edge
   always @(posedge clk) begin
      for (int i = 0; i < NLIM; i++) begin
         if (!rst_n) begin
            m_cnt[i] = 0; m_flt[i] = 0; m_stat[i] = 0; m_prev[i] = 0;
         end else begin
            int c, k, set, lim, v, viol;
            bit hit;
            c = i / 4; k = i % 4;
            set = int'(cfg_run[i*2 +: 2]);
            lim = int'(cfg_lim[i*DW +: DW]);
            hit = smp_vld && (int'(smp_ch) == c);
            v = sx(int'(smp_val), cfg_signed[c]);
            if (k >= 2) viol = (lim != FULL - 1) && (v > sx(lim, cfg_signed[c]));
            else        viol = (lim != 0) && (v < sx(lim, cfg_signed[c]));
            if (hit) m_stat[i] = viol;
            if (set != m_prev[i]) begin
               m_cnt[i] = 0; m_flt[i] = 0;
            end else if (hit) begin
               if (viol) begin
                  if (m_cnt[i] < need_of(set)) m_cnt[i]++;
                  m_flt[i] = (m_cnt[i] >= need_of(set));
               end else begin
                  m_cnt[i] = 0; m_flt[i] = 0;
               end
            end
            m_prev[i] = set;
         end
      end
   end

   // model comparison on every falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int i = 0; i < NLIM; i++) begin
            checks++;
            if (lim_fault[i] !== m_flt[i][0]) begin
               failures++;
               $display("FAIL R2 lim_fault[%0d] actual=%0b expected=%0b", i, lim_fault[i], m_flt[i][0]);
            end
            checks++;
            if (live_stat[i] !== m_stat[i][0]) begin
               failures++;
               $display("FAIL R7 live_stat[%0d] actual=%0b expected=%0b", i, live_stat[i], m_stat[i][0]);
            end
         end
         for (int c = 0; c < NCH; c++) begin
            checks++;
            if (ch_fault[c] !== (m_flt[c*4] | m_flt[c*4+1] | m_flt[c*4+2] | m_flt[c*4+3]) != 0) begin
               failures++;
               $display("FAIL R4 ch_fault[%0d] actual=%0b", c, ch_fault[c]);
            end
         end
      end
   end

   task automatic chk(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b", req, got, exp);
      end
   endtask

   task automatic samp(input int ch, input int val);
      @(negedge clk);
      smp_vld = 1'b1; smp_ch = CHW'(ch); smp_val = DW'(val);
      @(negedge clk);
      smp_vld = 1'b0;
   endtask

   task automatic set_lim(input int c, input int k, input int v);
      cfg_lim[(c*4+k)*DW +: DW] = DW'(v);
   endtask

   task automatic set_run(input int c, input int k, input int code);
      @(negedge clk);
      cfg_run[(c*4+k)*2 +: 2] = 2'(code);
      @(negedge clk);
   endtask

   task automatic finish_up();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      failures++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      for (int c = 0; c < NCH; c++) begin
         set_lim(c, 0, 0); set_lim(c, 1, 0);
         set_lim(c, 2, FULL - 1); set_lim(c, 3, FULL - 1);
      end
      cfg_run = '0;
      cfg_signed = '0;
      repeat (3) @(negedge clk);
      chk("R1 lim_fault in reset", |lim_fault, 1'b0);
      chk("R1 live_stat in reset", |live_stat, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ch_fault after reset", |ch_fault, 1'b0);

      // ch0 upper A, run of 4
      set_lim(0, 2, 500);
      set_run(0, 2, 2);
      repeat (3) samp(0, 501);
      chk("R2 three of four", lim_fault[2], 1'b0);
      samp(0, 501);
      chk("R2 four of four", lim_fault[2], 1'b1);
      chk("R4 channel 0 or", ch_fault[0], 1'b1);
      samp(0, 500);
      chk("R5 equal not beyond", live_stat[2], 1'b0);
      chk("R3 good sample clears", lim_fault[2], 1'b0);

      // interleaved run
      samp(0, 600); samp(1, 600); @(negedge clk);
      samp(0, 600); samp(2, 7); samp(0, 600);
      chk("R9 run still short", lim_fault[2], 1'b0);
      samp(3, 9); samp(0, 600);
      chk("R9 interleaved run completes", lim_fault[2], 1'b1);

      // setting change clears
      set_run(0, 2, 0);
      chk("R10 setting change clears", lim_fault[2], 1'b0);
      samp(0, 501);
      chk("R2 run of one", lim_fault[2], 1'b1);
      samp(0, 499);
      chk("R3 clear again", lim_fault[2], 1'b0);

      // disabled encodings
      samp(1, FULL - 1);
      chk("R6 upper all ones", lim_fault[7], 1'b0);
      samp(1, 0);
      chk("R6 lower zero", live_stat[4], 1'b0);
      chk("R6 channel 1 quiet", ch_fault[1], 1'b0);

      // signed versus unsigned lower bound of -160
      cfg_signed[2] = 1'b1;
      set_lim(2, 0, FULL - 160);
      set_lim(3, 0, FULL - 160);
      samp(2, 10);
      chk("R8 signed +10 above -160", lim_fault[8], 1'b0);
      samp(2, FULL - 161);
      chk("R8 signed -161 below -160", lim_fault[8], 1'b1);
      samp(3, 10);
      chk("R8 unsigned 10 below 864", lim_fault[12], 1'b1);
      chk("R7 status follows", live_stat[12], 1'b1);
      samp(3, FULL - 160);
      chk("R5 lower equal not beyond", live_stat[12], 1'b0);

      // run of six on upper B of ch1
      set_lim(1, 3, 300);
      set_run(1, 3, 3);
      repeat (5) samp(1, 301);
      chk("R2 five of six", lim_fault[7], 1'b0);
      samp(1, 301);
      chk("R2 six of six", lim_fault[7], 1'b1);
      samp(1, 301);
      chk("R2 saturated stays", lim_fault[7], 1'b1);

      // random phase, model compared each clock
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk);
         if (n % 150 == 0) begin
            int i;
            i = $urandom_range(NLIM - 1);
            cfg_run[i*2 +: 2] = 2'($urandom_range(3));
            cfg_lim[i*DW +: DW] = DW'($urandom_range(FULL - 1));
            cfg_signed[i/4] = 1'($urandom_range(1));
         end
         smp_vld = ($urandom_range(3) != 0);
         smp_ch = CHW'($urandom_range(NCH - 1));
         begin
            int i, base;
            i = int'(smp_ch) * 4 + $urandom_range(3);
            base = int'(cfg_lim[i*DW +: DW]);
            smp_val = DW'(base + $urandom_range(6) - 3);
         end
      end
      @(negedge clk);
      smp_vld = 1'b0;
      repeat (2) @(negedge clk);
      finish_up();
   end
endmodule